// File: doc/BRIEF.md
# PHY Control-Port Handshake Sequencer

This block turns a single register command into the chain of strobe phases a PHY control-register port expects. A command names a direction (write or read), a 16-bit register address and, for writes, a 16-bit data value. When `start` is accepted, the sequencer drives a 32-bit control word toward the PHY. Every phase of the chain waits for the PHY acknowledge to reach a set level before the next phase begins. The control word holds the address or data value in its low half, and separate strobe bits above it.

Each phase begins by loading its control word. The sequencer then samples the acknowledge at a fixed spacing of `POLL_CYCLES` clock cycles. It takes at most `MAX_RETRY + 1` samples. If the expected level has not appeared by the last of them, the command aborts: the control word returns to zero and `done` and `error` pulse together. At the end of a read, the value the PHY presents on its status input is returned on `rdData`.

A package helper builds the 16-bit reference-clock override word from its fields. A caller can then send that word with an ordinary write command.

Top module: `phyRegHandshake`

## Requirements
- R1: After reset, and at any time the block is not busy, `phyCtl` is all zeros and `busy`, `done` and `error` are low.
- R2: Layout of `phyCtl`: bits 15:0 carry the value; bit 16 is capture-address, bit 17 is capture-data, bit 18 is write and bit 19 is read. At most one of bits 19:16 is set at a time, and bits 31:20 are always zero.
- R3: Every command opens with the address phase. The address is driven with no strobe for exactly one cycle. The address is then driven with bit 16 set until acknowledge is seen high. Finally the address is driven with no strobe until acknowledge is seen low.
- R4: A write continues with four more phases, in this order. First the data with bit 17 set, waiting for ack high. Then the data alone, waiting for ack low. Then the data with bit 18 set, waiting for ack high. Last an all-zero word, waiting for ack low.
- R5: A read continues with two more phases. First only bit 19 is set, waiting for ack high. `rdData` takes `phyStatus` at the sample where the high level is seen. Then an all-zero word is driven, waiting for ack low.
- R6: A word carrying a strobe is only replaced after acknowledge was sampled high, unless the command aborts.
- R7: Acknowledge is sampled on the first cycle of each waiting phase and then every `POLL_CYCLES` cycles. If the sample with index `MAX_RETRY` (counting from zero) still misses, `phyCtl` returns to zero, `done` and `error` pulse, and the block returns to idle. An abort in the capture-address phase therefore ends `2 + MAX_RETRY*POLL_CYCLES` cycles after the start edge.
- R8: A matching level seen on the final allowed sample completes the phase normally.
- R9: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `start` has no effect while busy.
- R10: `done` is a one-cycle pulse at the end of every command. `error` is high only together with `done`, and only on an abort.
- R11: The package function `refClkWord` packs its fields as follows: bit 15 is enable (always 1), bits 14:13 prescale, bits 12:8 feedback divider, bits 7:6 secondary divider, bits 5:3 integral gain and bits 2:0 proportional gain. For a 25 MHz reference this gives 16'hA687, and for 50 MHz it gives 16'h8687.
- R12: A synchronous reset in the middle of a command returns the block to idle at the next edge, with `phyCtl` zero and no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a command when idle |
| opRead | input | 1 | 1 = read, 0 = write |
| cmdAddr | input | 16 | PHY register address |
| cmdData | input | 16 | Write data |
| phyAck | input | 1 | Acknowledge from the PHY |
| phyStatus | input | 16 | Status/read data from the PHY |
| phyCtl | output | 32 | Control word toward the PHY |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Abort indication, valid with done |
| rdData | output | 16 | Value captured during a read |

## Verification
Some rules of the control word hold on every cycle, and the bound checker watches them. These are: the upper bits stay zero, at most one strobe is set, the word is zero whenever the block is idle or finishing, `done` is a single-cycle pulse, `error` appears only with `done`, and `busy` falls only on `done`. The checker also ensures that a strobe word is never dropped without an acknowledge unless the command aborts. Other properties span a whole command, and only the bench's scenarios show them. These are the exact order of control words for writes and reads, the value returned on `rdData`, the cycle on which a timeout ends, and the boundary between a level caught on the last sample and one that arrives a cycle too late. The same holds for a `start` pulse arriving while busy, which must leave the command unchanged, and for a reset in mid-command.

// File: rtl/phyRegPkg.sv
package phyRegPkg;

  // strobe bit offsets above the value field (a PHY decodes these positions)
  localparam int STB_CAP_ADDR = 0;
  localparam int STB_CAP_DATA = 1;
  localparam int STB_WRITE    = 2;
  localparam int STB_READ     = 3;
  localparam int NUM_STB      = 4;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_ADDR,
    SEL_ADDR_CAP,
    SEL_DATA_CAP,
    SEL_DATA,
    SEL_DATA_WR,
    SEL_RD
  } wordSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR_CAP,
    ST_ADDR_REL,
    ST_DATA_CAP,
    ST_DATA_REL,
    ST_WR_SET,
    ST_WR_REL,
    ST_RD_SET,
    ST_RD_REL
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchCmd;
    logic     loadWord;
    wordSel_e wordSel;
    logic     restartPoll;
    logic     missSample;
    logic     captureRd;
  } seqStrobes_t;

  // reference-clock override word builder
  function automatic logic [15:0] refClkWord(
    input logic [1:0] prescale,
    input logic [4:0] fbDiv,
    input logic [1:0] fbDiv5,
    input logic [2:0] intGain,
    input logic [2:0] propGain
  );
    return {1'b1, prescale, fbDiv, fbDiv5, intGain, propGain};
  endfunction

  localparam logic [15:0] REFCLK_WORD_25M = refClkWord(2'b01, 5'd6, 2'd2, 3'd0, 3'd7);
  localparam logic [15:0] REFCLK_WORD_50M = refClkWord(2'b00, 5'd6, 2'd2, 3'd0, 3'd7);

endpackage

// File: rtl/phyRegDatapath.sv
module phyRegDatapath
  import phyRegPkg::*;
#(
  parameter int VAL_W       = 16,
  parameter int CTL_W       = 32,
  parameter int MAX_RETRY   = 100,
  parameter int POLL_CYCLES = 25000
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       stb,
  input  logic [VAL_W-1:0]  cmdAddr,
  input  logic [VAL_W-1:0]  cmdData,
  input  logic [VAL_W-1:0]  phyStatus,
  output logic [CTL_W-1:0]  phyCtl,
  output logic [VAL_W-1:0]  rdData,
  output logic              pollDue,
  output logic              retryLast
);

  localparam int RETRY_W = $clog2(MAX_RETRY + 1) > 0 ? $clog2(MAX_RETRY + 1) : 1;
  localparam int TIMER_W = $clog2(POLL_CYCLES) > 0 ? $clog2(POLL_CYCLES) : 1;
  localparam logic [RETRY_W-1:0] RETRY_END  = RETRY_W'(MAX_RETRY);
  localparam logic [TIMER_W-1:0] TIMER_LOAD = TIMER_W'(POLL_CYCLES - 1);

  logic [VAL_W-1:0]   addrQ, dataQ, addrSrc, dataSrc;
  logic [RETRY_W-1:0] retryCnt;
  logic [TIMER_W-1:0] pollTimer;
  logic [CTL_W-1:0]   ctlQ, nextWord;
  logic [VAL_W-1:0]   rdQ, nextVal;
  logic [NUM_STB-1:0] nextStb;

  assign addrSrc = stb.latchCmd ? cmdAddr : addrQ;
  assign dataSrc = stb.latchCmd ? cmdData : dataQ;

  always_comb begin
    nextVal = '0;
    nextStb = '0;
    unique case (stb.wordSel)
      SEL_ZERO:     ;
      SEL_ADDR:     nextVal = addrSrc;
      SEL_ADDR_CAP: begin nextVal = addrSrc; nextStb[STB_CAP_ADDR] = 1'b1; end
      SEL_DATA_CAP: begin nextVal = dataSrc; nextStb[STB_CAP_DATA] = 1'b1; end
      SEL_DATA:     nextVal = dataSrc;
      SEL_DATA_WR:  begin nextVal = dataSrc; nextStb[STB_WRITE] = 1'b1; end
      SEL_RD:       nextStb[STB_READ] = 1'b1;
      default:      ;
    endcase
    nextWord = '0;
    nextWord[VAL_W-1:0] = nextVal;
    nextWord[VAL_W +: NUM_STB] = nextStb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      dataQ <= '0;
      ctlQ  <= '0;
      rdQ   <= '0;
    end else begin
      if (stb.latchCmd) begin
        addrQ <= cmdAddr;
        dataQ <= cmdData;
      end
      if (stb.loadWord) ctlQ <= nextWord;
      if (stb.captureRd) rdQ <= phyStatus;
    end
  end

  // sample spacing timer and bounded retry counter
  always_ff @(posedge clk) begin
    if (rst || stb.restartPoll) begin
      retryCnt  <= '0;
      pollTimer <= '0;
    end else if (stb.missSample) begin
      retryCnt  <= retryCnt + 1'b1;
      pollTimer <= TIMER_LOAD;
    end else if (pollTimer != '0) begin
      pollTimer <= pollTimer - 1'b1;
    end
  end

  assign pollDue   = (pollTimer == '0);
  assign retryLast = (retryCnt == RETRY_END);
  assign phyCtl    = ctlQ;
  assign rdData    = rdQ;

endmodule

// File: rtl/phyRegCtrl.sv
module phyRegCtrl
  import phyRegPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        opRead,
  input  logic        phyAck,
  input  logic        pollDue,
  input  logic        retryLast,
  output seqStrobes_t stb,
  output logic        busy,
  output logic        done,
  output logic        error
);

  seqState_e state, nextState;
  logic      isRead, nextRead;
  logic      expAck, finishOk, abort;
  logic      doneQ, errQ;

  always_comb begin
    stb       = '0;
    stb.wordSel = SEL_ZERO;
    nextState = state;
    nextRead  = isRead;
    finishOk  = 1'b0;
    abort     = 1'b0;
    expAck    = state inside {ST_ADDR_CAP, ST_DATA_CAP, ST_WR_SET, ST_RD_SET};
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.latchCmd = 1'b1;
          stb.loadWord = 1'b1;
          stb.wordSel  = SEL_ADDR;
          nextRead     = opRead;
          nextState    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        stb.loadWord    = 1'b1;
        stb.wordSel     = SEL_ADDR_CAP;
        stb.restartPoll = 1'b1;
        nextState       = ST_ADDR_CAP;
      end
      default: begin
        if (pollDue) begin
          if (phyAck == expAck) begin
            stb.loadWord    = 1'b1;
            stb.restartPoll = 1'b1;
            case (state)
              ST_ADDR_CAP: begin stb.wordSel = SEL_ADDR; nextState = ST_ADDR_REL; end
              ST_ADDR_REL: begin
                stb.wordSel = isRead ? SEL_RD : SEL_DATA_CAP;
                nextState   = isRead ? ST_RD_SET : ST_DATA_CAP;
              end
              ST_DATA_CAP: begin stb.wordSel = SEL_DATA; nextState = ST_DATA_REL; end
              ST_DATA_REL: begin stb.wordSel = SEL_DATA_WR; nextState = ST_WR_SET; end
              ST_WR_SET:   nextState = ST_WR_REL;
              ST_RD_SET:   begin stb.captureRd = 1'b1; nextState = ST_RD_REL; end
              default:     begin finishOk = 1'b1; nextState = ST_IDLE; end
            endcase
          end else if (retryLast) begin
            stb.loadWord    = 1'b1;
            stb.restartPoll = 1'b1;
            abort           = 1'b1;
            nextState       = ST_IDLE;
          end else begin
            stb.missSample = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      state  <= nextState;
      isRead <= nextRead;
      doneQ  <= finishOk | abort;
      errQ   <= abort;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = doneQ;
  assign error = errQ;

endmodule

// File: rtl/phyRegHandshake.sv
module phyRegHandshake
  import phyRegPkg::*;
#(
  parameter int VAL_W       = 16,
  parameter int CTL_W       = 32,
  parameter int MAX_RETRY   = 100,
  parameter int POLL_CYCLES = 25000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             opRead,
  input  logic [VAL_W-1:0] cmdAddr,
  input  logic [VAL_W-1:0] cmdData,
  input  logic             phyAck,
  input  logic [VAL_W-1:0] phyStatus,
  output logic [CTL_W-1:0] phyCtl,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [VAL_W-1:0] rdData
);

  seqStrobes_t stb;
  logic        pollDue, retryLast;

  phyRegCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .opRead    (opRead),
    .phyAck    (phyAck),
    .pollDue   (pollDue),
    .retryLast (retryLast),
    .stb       (stb),
    .busy      (busy),
    .done      (done),
    .error     (error)
  );

  phyRegDatapath #(
    .VAL_W       (VAL_W),
    .CTL_W       (CTL_W),
    .MAX_RETRY   (MAX_RETRY),
    .POLL_CYCLES (POLL_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .phyStatus (phyStatus),
    .phyCtl    (phyCtl),
    .rdData    (rdData),
    .pollDue   (pollDue),
    .retryLast (retryLast)
  );

endmodule

// File: rtl/phyRegChecker.sv
module phyRegChecker #(
  parameter int VAL_W = 16,
  parameter int CTL_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             phyAck,
  input logic [CTL_W-1:0] phyCtl,
  input logic             busy,
  input logic             done,
  input logic             error
);

  localparam int STB_LO = VAL_W;
  localparam int STB_N  = 4;

  logic [STB_N-1:0] strobes;
  assign strobes = phyCtl[STB_LO +: STB_N];

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phyCtl >> (STB_LO + STB_N)) == '0); // R2

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes)); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy |-> phyCtl == '0); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    error |-> done); // R10

  AST_END_CLEAN: assert property (@(posedge clk) disable iff (rst)
    done |-> (phyCtl == '0 && !busy)); // R7

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> done); // R9

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobes) != '0 && phyCtl != $past(phyCtl) && !done)
      |-> $past(phyAck)); // R6

endmodule

bind phyRegHandshake phyRegChecker #(
  .VAL_W (VAL_W),
  .CTL_W (CTL_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .phyAck (phyAck),
  .phyCtl (phyCtl),
  .busy   (busy),
  .done   (done),
  .error  (error)
);

// File: tb/test_phyRegHandshake.sv
`timescale 1ns/1ps
module test_phyRegHandshake;

  localparam int POLL = 4;
  localparam int MAXR = 3;
  localparam int ABORT_CYC = 2 + MAXR * POLL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        opRead = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic [15:0] cmdData = '0;
  logic        phyAck = 1'b0;
  logic [15:0] phyStatus;
  logic [31:0] phyCtl;
  logic        busy, done, error;
  logic [15:0] rdData;

  int nChecks = 0;
  int nErr = 0;

  phyRegHandshake #(.MAX_RETRY(MAXR), .POLL_CYCLES(POLL)) i_phyRegHandshake (
    .clk(clk), .rst(rst), .start(start), .opRead(opRead),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .phyAck(phyAck),
    .phyStatus(phyStatus), .phyCtl(phyCtl), .busy(busy),
    .done(done), .error(error), .rdData(rdData)
  );

  always #4 clk = ~clk;

  // PHY model
  int          ackLat = 1;
  bit          stuckLow = 1'b0;
  int          lagCnt = 0;
  logic [15:0] phyAddr = '0;
  logic [15:0] phyData = '0;
  logic        wrPrev = 1'b0;
  logic [15:0] mem [16];

  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (stuckLow) begin
      phyAck <= 1'b0;
      lagCnt <= 0;
    end else if (phyAck != (|phyCtl[19:16])) begin
      if (lagCnt >= ackLat) begin
        phyAck <= |phyCtl[19:16];
        lagCnt <= 0;
      end else lagCnt <= lagCnt + 1;
    end else lagCnt <= 0;
    if (phyCtl[16]) phyAddr <= phyCtl[15:0];
    if (phyCtl[17]) phyData <= phyCtl[15:0];
    if (phyCtl[18] && !wrPrev) mem[phyAddr[3:0]] <= phyData;
    wrPrev <= phyCtl[18];
  end

  assign phyStatus = mem[phyAddr[3:0]];

  // control word monitor
  logic [31:0] seenQ[$];
  logic [31:0] lastCtl = '0;
  int layoutBad = 0;

  always @(negedge clk) begin
    if (phyCtl !== lastCtl) begin
      seenQ.push_back(phyCtl);
      lastCtl = phyCtl;
    end
    if (phyCtl[31:20] != '0 || !$onehot0(phyCtl[19:16])) layoutBad++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkSeq(input string req, input logic [31:0] exp[$]);
    bit same = (seenQ.size() == exp.size());
    if (same) foreach (exp[i]) if (seenQ[i] !== exp[i]) same = 1'b0;
    chk(same, req, "control word order (count)", seenQ.size(), exp.size());
    if (!same) foreach (seenQ[i]) $display("  seen[%0d] = %h", i, seenQ[i]);
  endtask

  task automatic settle();
    ackLat = 1;
    stuckLow = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  // launch one command and wait for done; optional stray start at cycle spamAt
  task automatic runTxn(input bit rd, input logic [15:0] a, input logic [15:0] d,
                        input int spamAt, output int cyc, output bit err,
                        output int busyGaps, output int doneCnt);
    seenQ.delete();
    cyc = 0; busyGaps = 0; doneCnt = 0;
    @(negedge clk);
    opRead = rd; cmdAddr = a; cmdData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!busy) busyGaps++;
    forever begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (done) begin doneCnt++; break; end
      if (!busy) busyGaps++;
      if (cyc == spamAt) begin
        opRead = ~rd; cmdAddr = a ^ 16'h0001; cmdData = ~d; start = 1'b1;
      end
      if (cyc > 5000) break;
    end
    err = error;
    repeat (4) begin
      @(negedge clk);
      if (done) doneCnt++;
    end
  endtask

  task automatic tReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(phyCtl == '0, "R1", "phyCtl in reset", phyCtl, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R1", "busy/done/error idle",
        {busy, done, error}, 0);
    chk(phyCtl == '0, "R1", "phyCtl idle", phyCtl, 0);
  endtask

  task automatic tWrite();
    int c, g, dn; bit e;
    runTxn(1'b0, 16'h0005, 16'h1234, 0, c, e, g, dn);
    chkSeq("R4", '{32'h0000_0005, 32'h0001_0005, 32'h0000_0005,
                   32'h0002_1234, 32'h0000_1234, 32'h0004_1234, 32'h0000_0000});
    chk(seenQ.size() >= 3 && seenQ[0] == 32'h5 && seenQ[1] == 32'h1_0005 && seenQ[2] == 32'h5,
        "R3", "address phase words", seenQ.size(), 3);
    chk(e == 1'b0 && dn == 1, "R10", "write done once no error", {e, dn[3:0]}, 1);
    chk(g == 0, "R9", "busy gaps during write", g, 0);
    chk(mem[5] == 16'h1234, "R4", "PHY register after write", mem[5], 16'h1234);
  endtask

  task automatic tRead();
    int c, g, dn; bit e;
    runTxn(1'b1, 16'h0005, 16'h0000, 0, c, e, g, dn);
    chkSeq("R5", '{32'h0000_0005, 32'h0001_0005, 32'h0000_0005,
                   32'h0008_0000, 32'h0000_0000});
    chk(rdData == 16'h1234, "R5", "read data", rdData, 16'h1234);
    chk(e == 1'b0 && dn == 1, "R10", "read done once no error", {e, dn[3:0]}, 1);
  endtask

  task automatic tRefClk();
    int c, g, dn; bit e;
    logic [15:0] exp25 = (16'h1 << 15) | (16'h1 << 13) | (16'h6 << 8) | (16'h2 << 6) | 16'h7;
    logic [15:0] exp50 = (16'h1 << 15) | (16'h6 << 8) | (16'h2 << 6) | 16'h7;
    chk(phyRegPkg::REFCLK_WORD_25M == exp25, "R11", "25 MHz word", phyRegPkg::REFCLK_WORD_25M, exp25);
    chk(phyRegPkg::refClkWord(2'b00, 5'd6, 2'd2, 3'd0, 3'd7) == exp50, "R11", "50 MHz word",
        phyRegPkg::refClkWord(2'b00, 5'd6, 2'd2, 3'd0, 3'd7), exp50);
    runTxn(1'b0, 16'h0009, exp25, 0, c, e, g, dn);
    runTxn(1'b1, 16'h0009, 16'h0000, 0, c, e, g, dn);
    chk(rdData == exp25, "R11", "override word read back", rdData, exp25);
  endtask

  task automatic tTimeout();
    int c, g, dn; bit e;
    stuckLow = 1'b1;
    runTxn(1'b0, 16'h0007, 16'hAAAA, 0, c, e, g, dn);
    chk(c == ABORT_CYC, "R7", "abort cycle", c, ABORT_CYC);
    chk(e == 1'b1 && dn == 1, "R7", "done with error", {e, dn[3:0]}, 17);
    chk(phyCtl == '0 && busy == 1'b0, "R7", "idle after abort", {busy, phyCtl[30:0]}, 0);
    chkSeq("R7", '{32'h0000_0007, 32'h0001_0007, 32'h0000_0000});
    settle();
  endtask

  task automatic tLastSample();
    int c, g, dn; bit e;
    ackLat = 11;
    runTxn(1'b0, 16'h0002, 16'hBEEF, 0, c, e, g, dn);
    chk(e == 1'b0, "R8", "ack on last sample accepted", e, 0);
    chk(mem[2] == 16'hBEEF, "R8", "slow write landed", mem[2], 16'hBEEF);
    settle();
    ackLat = 12;
    runTxn(1'b0, 16'h0003, 16'h1111, 0, c, e, g, dn);
    chk(e == 1'b1 && c == ABORT_CYC, "R7", "ack one cycle late aborts", c, ABORT_CYC);
    settle();
  endtask

  task automatic tStartIgnored();
    int c, g, dn; bit e;
    runTxn(1'b0, 16'h0004, 16'h0F0F, 5, c, e, g, dn);
    chkSeq("R9", '{32'h0000_0004, 32'h0001_0004, 32'h0000_0004,
                   32'h0002_0F0F, 32'h0000_0F0F, 32'h0004_0F0F, 32'h0000_0000});
    chk(dn == 1 && g == 0 && busy == 1'b0, "R9", "single command despite start",
        {busy, g[3:0], dn[3:0]}, 1);
    chk(mem[5] == 16'h1234, "R9", "other register untouched", mem[5], 16'h1234);
  endtask

  task automatic tResetMid();
    int c, g, dn; bit e;
    @(negedge clk);
    opRead = 1'b0; cmdAddr = 16'h0006; cmdData = 16'h5555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(phyCtl == '0 && busy == 1'b0 && done == 1'b0, "R12", "state after mid reset",
        {busy, done, phyCtl[29:0]}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R12", "no done after reset", done, 0);
    settle();
    runTxn(1'b1, 16'h0005, 16'h0000, 0, c, e, g, dn);
    chk(rdData == 16'h1234 && e == 1'b0, "R12", "read after reset", rdData, 16'h1234);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tReset();
    tWrite();
    tRead();
    tRefClk();
    tTimeout();
    tLastSample();
    tStartIgnored();
    tResetMid();
    chk(layoutBad == 0, "R2", "control word layout violations", layoutBad, 0);
    summary();
    $finish;
  end

endmodule